// File: doc/BRIEF.md
# Second-Order Digital Delta-Sigma Bitstream Modulator

This block is a fully digital, cycle-accurate model of a second-order, single-bit delta-sigma modulator. It serves as a stimulus source for decimation filters. Each rising clock edge takes one signed 16-bit input code, which stands for a differential input voltage. The block produces a one-bit stream whose density of ones tracks the code. Two saturating accumulators run in cascade. A sign comparator on the second accumulator sets the output bit, and that bit is fed back as a ±K step into both accumulators.

The input range is calibrated so that code ±9216 stands for ±250 mV. At those codes the stream is 78.125 % or 21.875 % ones. Code ±11796 stands for ±320 mV, and at or beyond it the stream is pinned at all ones or all zeros. The output bit is registered on the falling clock edge. A consumer sampling on the rising edge therefore sees a value that has been stable for half a period.

Top module: `dsm2_mod`

## Requirements
- R1: With feedback value f = +K when the comparator bit is 1 and f = -K when it is 0 (K = 16384), each rising edge out of reset updates A1 <= sat(A1 + x - f) and A2 <= sat(A2 + A1 - 2f). Here x is the clamped input. A2 uses the value of A1 from before the edge. Both accumulators are 24-bit signed and saturate at their limits instead of wrapping. Feeding the registered A1 and a doubled step into A2 gives the same noise shaping as a second integrator that takes the updated A1 and a single step.
- R2: The comparator bit is 1 when A2 >= 0 and 0 otherwise, and the feedback step applied at a rising edge is the comparator bit of the cycle before it. With input 0 after reset, the stream is therefore 1,0,0,1,1,0,0,1.
- R3: A zero input code gives a ones density of 50 % within ±0.5 % over 8192 output bits.
- R4: Inside ±9216 the ones density is 0.5 + x/(2K). Code +9216 gives 78.125 %, code -9216 gives 21.875 %, and intermediate codes follow the same line, each within ±0.5 %.
- R5: Any input code >= +11796 makes every output bit 1, and any code <= -11796 makes every output bit 0. This includes the extreme codes +32767 and -32768. Such inputs are clamped to ±11796 before they reach A1.
- R6: `data_out` changes only at falling clock edges. It holds its value across every rising edge.
- R7: `rst` is synchronous and active high. A rising edge with `rst` high clears both accumulators. A falling edge with `rst` high forces `data_out` to 0. After release, the stream restarts from the cleared state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Modulator clock; accumulators update on its rising edge, output on its falling edge |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 16 | Signed two's-complement input code |
| data_out | output | 1 | Registered modulator bit |

## Verification
The hard-clipping region is the situation that is hardest to reach cleanly. With the input clamped to ±11796 the loop runs at 72 % of its feedback level. There the accumulators drift toward saturation, and only the override keeps the stream pinned. The bench reaches it by resetting before each vector, driving each overrange code, including the two extreme codes, for over eight thousand cycles, and requiring an exact count of all ones or all zeros. The in-range densities follow from the first accumulator's bound. This makes a tight tolerance safe, and a wrong feedback level, sign or update path moves the count far outside it.

// File: rtl/dsm_pkg.sv
package dsm_pkg;
  // Output override requested by the input conditioner
  typedef enum logic [1:0] {
    OVR_NONE = 2'd0,
    OVR_HIGH = 2'd1,
    OVR_LOW  = 2'd2
  } ovr_e;
endpackage

// File: rtl/dsm_clamp.sv
module dsm_clamp
  import dsm_pkg::*;
#(
  parameter int IN_W      = 16,
  parameter int CLIP_CODE = 11796
) (
  input  logic signed [IN_W-1:0] din,
  output logic signed [IN_W-1:0] din_clamped,
  output ovr_e                   ovr
);
  localparam logic signed [IN_W-1:0] CLIP_P = IN_W'(CLIP_CODE);
  localparam logic signed [IN_W-1:0] CLIP_N = -CLIP_P;

  always_comb begin
    if (din >= CLIP_P) begin
      din_clamped = CLIP_P;
      ovr         = OVR_HIGH;
    end else if (din <= CLIP_N) begin
      din_clamped = CLIP_N;
      ovr         = OVR_LOW;
    end else begin
      din_clamped = din;
      ovr         = OVR_NONE;
    end
  end
endmodule

// File: rtl/dsm_integ.sv
module dsm_integ #(
  parameter int ACC_W     = 24,
  parameter int DAC_LEVEL = 16384,
  parameter int FB_SHIFT  = 0
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic signed [ACC_W-1:0] term,
  input  logic                    fb,
  output logic signed [ACC_W-1:0] acc_q
);
  localparam int SW = ACC_W + 2;
  localparam logic signed [SW-1:0] STEP_P = SW'(DAC_LEVEL * (1 << FB_SHIFT));
  localparam logic signed [SW-1:0] STEP_N = -STEP_P;
  localparam logic signed [SW-1:0] SAT_HI = {{3{1'b0}}, {(ACC_W-1){1'b1}}};
  localparam logic signed [SW-1:0] SAT_LO = {{3{1'b1}}, {(ACC_W-1){1'b0}}};

  logic signed [SW-1:0]    acc_x, term_x, sum;
  logic signed [ACC_W-1:0] acc_d;

  assign acc_x  = {{2{acc_q[ACC_W-1]}}, acc_q};
  assign term_x = {{2{term[ACC_W-1]}}, term};

  always_comb begin
    sum = acc_x + term_x - (fb ? STEP_P : STEP_N);
    if (sum > SAT_HI)      acc_d = SAT_HI[ACC_W-1:0];
    else if (sum < SAT_LO) acc_d = SAT_LO[ACC_W-1:0];
    else                   acc_d = sum[ACC_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) acc_q <= '0;
    else     acc_q <= acc_d;
  end
endmodule

// File: rtl/dsm_out_reg.sv
module dsm_out_reg
  import dsm_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic cmp_bit,
  input  ovr_e ovr,
  output logic data_out
);
  always_ff @(negedge clk) begin
    if (rst) begin
      data_out <= 1'b0;
    end else begin
      unique case (ovr)
        OVR_HIGH: data_out <= 1'b1;
        OVR_LOW:  data_out <= 1'b0;
        default:  data_out <= cmp_bit;
      endcase
    end
  end
endmodule

// File: rtl/dsm2_mod.sv
module dsm2_mod
  import dsm_pkg::*;
#(
  parameter int IN_W      = 16,
  parameter int ACC_W     = 24,
  parameter int DAC_LEVEL = 16384,
  parameter int CLIP_CODE = 11796
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic signed [IN_W-1:0] din,
  output logic                   data_out
);
  localparam int NSTAGE = 2;
  localparam int EXT_W  = ACC_W - IN_W;

  logic signed [IN_W-1:0]  x_c;
  ovr_e                    ovr;
  logic signed [ACC_W-1:0] acc_q [NSTAGE];
  logic                    cmp_bit;

  dsm_clamp #(.IN_W(IN_W), .CLIP_CODE(CLIP_CODE)) u_clamp (
    .din(din), .din_clamped(x_c), .ovr(ovr)
  );

  // comparator: 1 when the last accumulator is non-negative
  assign cmp_bit = ~acc_q[NSTAGE-1][ACC_W-1];

  for (genvar s = 0; s < NSTAGE; s++) begin : g_stage
    logic signed [ACC_W-1:0] term;
    if (s == 0) begin : g_first
      assign term = {{EXT_W{x_c[IN_W-1]}}, x_c};
    end else begin : g_next
      assign term = acc_q[s-1];
    end
    dsm_integ #(
      .ACC_W(ACC_W), .DAC_LEVEL(DAC_LEVEL), .FB_SHIFT((s == 0) ? 0 : 1)
    ) u_integ (
      .clk(clk), .rst(rst), .term(term), .fb(cmp_bit), .acc_q(acc_q[s])
    );
  end

  dsm_out_reg u_out (
    .clk(clk), .rst(rst), .cmp_bit(cmp_bit), .ovr(ovr), .data_out(data_out)
  );
endmodule

// File: rtl/dsm2_checker.sv
module dsm2_checker #(
  parameter int IN_W      = 16,
  parameter int ACC_W     = 24,
  parameter int CLIP_CODE = 11796
) (
  input logic                    clk,
  input logic                    rst,
  input logic signed [IN_W-1:0]  din,
  input logic                    data_out,
  input logic signed [ACC_W-1:0] i1,
  input logic signed [ACC_W-1:0] i2
);
  localparam logic signed [IN_W-1:0]  CLIP_P = IN_W'(CLIP_CODE);
  localparam logic signed [IN_W-1:0]  CLIP_N = -CLIP_P;
  localparam logic signed [ACC_W-1:0] A_MAX  = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] A_MIN  = {1'b1, {(ACC_W-1){1'b0}}};

  logic hi, lo, rst_at_fall;
  assign hi = (din >= CLIP_P);
  assign lo = (din <= CLIP_N);

  always_ff @(negedge clk) rst_at_fall <= rst;

  // R7: a falling edge under reset leaves the output low
  always @(posedge clk) begin
    if (rst_at_fall) begin
      a_rst_out_r7: assert (data_out == 1'b0);
    end
  end

  // R5: overrange high pins the next output bit to 1
  p_force_hi_r5: assert property (@(negedge clk) disable iff (rst)
    (!$past(rst) && $past(hi)) |-> data_out);

  // R5: overrange low pins the next output bit to 0
  p_force_lo_r5: assert property (@(negedge clk) disable iff (rst)
    (!$past(rst) && $past(lo)) |-> !data_out);

  // R2: in range, the output follows the sign of the second accumulator
  p_out_cmp_r2: assert property (@(negedge clk) disable iff (rst)
    (!$past(rst) && !$past(hi) && !$past(lo)) |-> (data_out == !$past(i2[ACC_W-1])));

  // R1: a positive step always pulls the first accumulator down
  p_fb_down_r1: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(i2[ACC_W-1]) && ($past(i1) != A_MIN)) |-> (i1 < $past(i1)));

  // R1: a negative step always pushes the first accumulator up
  p_fb_up_r1: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(i2[ACC_W-1]) && ($past(i1) != A_MAX)) |-> (i1 > $past(i1)));
endmodule

bind dsm2_mod dsm2_checker #(
  .IN_W(IN_W), .ACC_W(ACC_W), .CLIP_CODE(CLIP_CODE)
) u_chk (
  .clk(clk), .rst(rst), .din(din), .data_out(data_out),
  .i1(acc_q[0]), .i2(acc_q[1])
);

// File: tb/sim_dsm2_mod.sv
module sim_dsm2_mod;
  localparam int CLK_PERIOD = 10;
  localparam int N_AVG      = 8192;
  localparam int SETTLE     = 16;
  localparam int K          = 16384;
  localparam int CLIP       = 11796;
  localparam int NVEC       = 9;
  localparam logic signed [15:0] VEC [NVEC] = '{
    16'sd0, 16'sd9216, -16'sd9216, 16'sd4608, -16'sd2000,
    16'sd11796, -16'sd11796, 16'sh7FFF, 16'sh8000
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic signed [15:0] din = '0;
  logic data_out;
  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dsm2_mod u0 (.clk(clk), .rst(rst), .din(din), .data_out(data_out));

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic do_reset(input logic signed [15:0] x);
    @(posedge clk); #2;
    rst = 1'b1;
    din = x;
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
  endtask

  task automatic next_bit(output logic b);
    @(posedge clk); #2;
    b = data_out;
  endtask

  initial begin
    logic b;
    logic [7:0] pat;
    int ones;
    pat = 8'b1001_1001;

    // R7: output low while held in reset
    repeat (4) @(posedge clk);
    #2 check(data_out == 1'b0, "R7", "output during reset", data_out, 0);

    // R1 R2: exact start-up pattern with zero input
    do_reset(16'sd0);
    for (int i = 0; i < 8; i++) begin
      next_bit(b);
      check(b == pat[7-i], "R2", $sformatf("zero-input bit %0d", i), b, pat[7-i]);
    end

    // R6: output stable across rising edges, changes at falling edges
    begin
      int diffs, toggles;
      logic pa, pb;
      diffs = 0; toggles = 0; pa = data_out;
      for (int i = 0; i < 32; i++) begin
        @(negedge clk); #2 pb = data_out;
        if (pb != pa) toggles++;
        @(posedge clk); #1;
        if (data_out != pb) diffs++;
        pa = data_out;
      end
      check(diffs == 0, "R6", "changes across rising edges", diffs, 0);
      check(toggles > 0, "R6", "changes at falling edges", toggles > 0, 1);
    end

    // R7: mid-run reset clears output and restarts the sequence
    @(posedge clk); #2 rst = 1'b1;
    @(posedge clk); #2;
    check(data_out == 1'b0, "R7", "output after mid-run reset", data_out, 0);
    rst = 1'b0;
    for (int i = 0; i < 4; i++) begin
      next_bit(b);
      check(b == pat[7-i], "R7", $sformatf("restart bit %0d", i), b, pat[7-i]);
    end

    // R3 R4 R5: density table
    for (int v = 0; v < NVEC; v++) begin
      real expd, tol;
      int  xi;
      string req;
      xi = int'(VEC[v]);
      if (xi >= CLIP) begin
        expd = real'(N_AVG); tol = 0.0; req = "R5";
      end else if (xi <= -CLIP) begin
        expd = 0.0; tol = 0.0; req = "R5";
      end else begin
        expd = real'(N_AVG) * (0.5 + real'(xi) / (2.0 * real'(K)));
        tol  = 0.005 * real'(N_AVG);
        req  = (xi == 0) ? "R3" : "R4";
      end
      do_reset(VEC[v]);
      repeat (SETTLE) begin @(posedge clk); #2; end
      ones = 0;
      for (int i = 0; i < N_AVG; i++) begin
        @(posedge clk); #2;
        ones += int'(data_out);
      end
      check((real'(ones) >= expd - tol) && (real'(ones) <= expd + tol), req,
            $sformatf("ones count for input %0d", xi), ones, int'(expd));
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule